// File: doc/BRIEF.md
# Packed Byte Permutation Unit

This block is the byte-permutation slice of a vector execution pipe. Each accepted request applies one of two byte-level rearrangements to a pair of vector operands and hands the result to the writeback stage one clock later.

The table-lookup operation treats the first operand as a table of bytes. Each byte of the second operand selects which table byte lands in the same result position. An index byte with its top bit set clears that result byte instead.

The window-extract operation joins the two operands into one double-length byte string, with the first operand on the high side. It then reads out one operand's worth of consecutive bytes, starting at a byte offset carried by the 8-bit immediate. Positions past the end of the joined string read as zero.

A width select runs either operation on full 128-bit operands or on 64-bit operands held in the low half of each input. Instruction decode and register access are handled elsewhere.

Top module: `vperm_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_valid` and `res_data` are cleared to zero at that edge.
- R2: `res_valid` at each clock edge takes the value `req_valid` had just before that edge, giving a latency of exactly one cycle.
- R3: With `op_kind`=0 (table lookup) and `full_width`=1, result byte i equals byte k of `opnd_a`, where k is bits [3:0] of byte i of `opnd_b`. Byte i occupies bits [8i+7:8i].
- R4: In table lookup, result byte i is zero whenever bit 7 of byte i of `opnd_b` is 1, at either width.
- R5: In table lookup, only bits [3:0] of an index byte select a byte in 128-bit mode, and only bits [2:0] in 64-bit mode. Bits [6:4] (128-bit mode) or [6:3] (64-bit mode) have no effect on the result.
- R6: With `op_kind`=1 (window extract) and `full_width`=1, the joined string is {`opnd_a`, `opnd_b`}, 32 bytes. Byte 0 of the string is byte 0 of `opnd_b` and byte 16 is byte 0 of `opnd_a`. Result byte j equals string byte `shift_imm`+j.
- R7: With window extract and `full_width`=0, the joined string is {`opnd_a`[63:0], `opnd_b`[63:0]}, 16 bytes. Result byte j, for j<8, equals string byte `shift_imm`+j.
- R8: In window extract, a result byte whose string position `shift_imm`+j lies past the end of the joined string is zero. An offset of 32 or more (128-bit) or 16 or more (64-bit) therefore yields an all-zero result.
- R9: With `full_width`=0, result bits [127:64] are zero for both operations, and bytes 8 to 15 of both operands have no effect.
- R10: In a cycle with `req_valid` low, `res_data` keeps its previous value whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| op_kind | input | 1 | 0 = table lookup, 1 = window extract |
| full_width | input | 1 | 1 = 128-bit operands, 0 = 64-bit operands in the low half |
| opnd_a | input | 128 | Table for lookup; high side of the joined string for extract |
| opnd_b | input | 128 | Index bytes for lookup; low side of the joined string for extract |
| shift_imm | input | 8 | Byte offset for window extract |
| res_valid | output | 1 | Result present |
| res_data | output | 128 | Result vector |

## Verification
The embedded assertions check the timing and masking rules on every cycle. They cover the one-cycle latency of the valid flag and the holding of the result while no request arrives. They also cover the zero upper half in 64-bit mode, the cleared byte 0 for an index byte with its top bit set, and the all-zero result of an extract at an out-of-range offset. The byte selection itself can only be shown by the bench's directed scenarios. These include identity and reversed index patterns, index bytes with junk middle bits, and extract offsets at 0, at the operand boundary, at the last valid byte and just past the end. The bench compares each result against its own byte-level model and against hand-derived values.

// File: rtl/vperm_pkg.sv
// Package: shared operation encoding and sizing helpers for the byte
// permutation unit. Assumes byte-granular vectors.
package vperm_pkg;

    typedef enum logic {
        OP_LOOKUP  = 1'b0,
        OP_EXTRACT = 1'b1
    } vperm_op_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/vperm_lookup.sv
// Module: vperm_lookup
// Byte table lookup. Every result byte is chosen from the table operand
// by the low index bits of the matching index byte, or cleared when the
// index byte's top bit is set. In narrow mode only the low half of the
// table is addressable and the upper result half is zero.
// Assumes NB is a power of two and at least 2.
module vperm_lookup #(
    parameter int NB = 16
) (
    input  logic                narrow_n,
    input  logic [NB*8-1:0]     table_v,
    input  logic [NB*8-1:0]     index_v,
    output logic [NB*8-1:0]     out_v
);
    localparam int IDX_W  = $clog2(NB);
    localparam int HALF   = NB / 2;

    // Unpack the table into an addressable byte array.
    logic [7:0] tbl_byte [NB];
    always_comb begin
        for (int k = 0; k < NB; k++) tbl_byte[k] = table_v[k*8 +: 8];
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0]       idx_byte;
        logic [IDX_W-1:0] sel;
        logic             clear;

        // Form the effective index for this lane from the mode.
        always_comb begin
            idx_byte = index_v[i*8 +: 8];
            if (narrow_n) sel = idx_byte[IDX_W-1:0];
            else          sel = {1'b0, idx_byte[IDX_W-2:0]};
            clear = idx_byte[7] || (!narrow_n && (i >= HALF));
        end

        // Drive the lane: selected table byte or zero.
        always_comb begin
            out_v[i*8 +: 8] = clear ? 8'h00 : tbl_byte[sel];
        end
    end

endmodule

// File: rtl/vperm_extract.sv
// Module: vperm_extract
// Double-width window extract. The high operand sits above the low operand
// to form a byte string of twice the operand length; a window of one
// operand length starting at the immediate byte offset is returned.
// Positions past the end of the string read as zero. In narrow mode only
// the low half of each operand joins the string and the window is half
// length. Assumes NB is a power of two and at least 2.
module vperm_extract #(
    parameter int NB = 16
) (
    input  logic                narrow_n,
    input  logic [NB*8-1:0]     hi_v,
    input  logic [NB*8-1:0]     lo_v,
    input  logic [7:0]          offset,
    output logic [NB*8-1:0]     out_v
);
    localparam int CAT_NB  = 2 * NB;
    localparam int CAT_IW  = $clog2(CAT_NB);
    localparam int HALF    = NB / 2;
    localparam int POS_W   = (CAT_IW > 8 ? CAT_IW : 8) + 2;

    // Joined byte string, arranged according to the width mode.
    logic [7:0] cat_byte [CAT_NB];
    always_comb begin
        for (int k = 0; k < CAT_NB; k++) begin
            if (narrow_n) begin
                cat_byte[k] = (k < NB) ? lo_v[k*8 +: 8] : hi_v[(k-NB)*8 +: 8];
            end else if (k < HALF) begin
                cat_byte[k] = lo_v[k*8 +: 8];
            end else if (k < NB) begin
                cat_byte[k] = hi_v[(k-HALF)*8 +: 8];
            end else begin
                cat_byte[k] = 8'h00;
            end
        end
    end

    // Length of the joined string in the current mode.
    logic [POS_W-1:0] cat_len;
    always_comb cat_len = narrow_n ? POS_W'(CAT_NB) : POS_W'(NB);

    for (genvar j = 0; j < NB; j++) begin : g_win
        logic [POS_W-1:0] pos;
        logic             in_range;

        // Locate this window byte in the joined string.
        always_comb begin
            pos      = POS_W'(offset) + POS_W'(j);
            in_range = (pos < cat_len) && (narrow_n || (j < HALF));
        end

        // Drive the window byte, zero when it falls off the string.
        always_comb begin
            out_v[j*8 +: 8] = in_range ? cat_byte[pos[CAT_IW-1:0]] : 8'h00;
        end
    end

endmodule

// File: rtl/vperm_unit.sv
// Module: vperm_unit (top)
// Byte permutation unit: selects table lookup or window extract, registers
// the chosen result on an accepted request, and flags it valid one cycle
// later. Result data holds between requests. Synchronous active-low reset.
// Assumes VEC_W is a multiple of 16 and a power of two in bytes.
module vperm_unit
    import vperm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              op_kind,
    input  logic              full_width,
    input  logic [VEC_W-1:0]  opnd_a,
    input  logic [VEC_W-1:0]  opnd_b,
    input  logic [7:0]        shift_imm,
    output logic              res_valid,
    output logic [VEC_W-1:0]  res_data
);
    localparam int NB      = VEC_W / BYTE_W;
    localparam int HALF_W  = VEC_W / 2;
    localparam int CAT_NB  = 2 * NB;

    vperm_op_e        op;
    logic [VEC_W-1:0] lookup_res;
    logic [VEC_W-1:0] extract_res;
    logic [VEC_W-1:0] next_res;

    // Decode the operation selector into the shared enum.
    always_comb op = vperm_op_e'(op_kind);

    vperm_lookup #(.NB(NB)) u_lookup (
        .narrow_n (full_width),
        .table_v  (opnd_a),
        .index_v  (opnd_b),
        .out_v    (lookup_res)
    );

    vperm_extract #(.NB(NB)) u_extract (
        .narrow_n (full_width),
        .hi_v     (opnd_a),
        .lo_v     (opnd_b),
        .offset   (shift_imm),
        .out_v    (extract_res)
    );

    // Pick the result of the requested operation.
    always_comb next_res = (op == OP_EXTRACT) ? extract_res : lookup_res;

    // Result register: load on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
        end else if (req_valid) begin
            res_data <= next_res;
        end
    end

    // Valid pipeline: one stage behind the request.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= req_valid;
    end

    // R2: valid follows request by exactly one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    // R10: data holds when no request
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(res_data));

    // R9: narrow mode leaves the upper half zero
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !full_width) |=> (res_data[VEC_W-1:HALF_W] == '0));

    // R4: top index bit clears byte 0 in lookup
    a_r4_byte0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !op_kind && opnd_b[7]) |=> (res_data[7:0] == 8'h00));

    // R8: offset past the whole string gives zero
    a_r8_far_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_kind && full_width && (int'(shift_imm) >= CAT_NB))
        |=> (res_data == '0));
    a_r8_far_offset_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_kind && !full_width && (int'(shift_imm) >= NB))
        |=> (res_data == '0));

endmodule

// File: tb/test_vperm_unit.sv
module test_vperm_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         op_kind;
    logic         full_width;
    logic [127:0] opnd_a;
    logic [127:0] opnd_b;
    logic [7:0]   shift_imm;
    logic         res_valid;
    logic [127:0] res_data;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    vperm_unit i_vperm_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_kind(op_kind),
        .full_width(full_width), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_imm(shift_imm), .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(input string tag, input logic [127:0] got,
                         input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Bench model of table lookup from R3/R4/R5/R9.
    function automatic logic [127:0] m_lookup(input logic [127:0] a,
                                              input logic [127:0] b,
                                              input logic w);
        logic [127:0] r = '0;
        for (int i = 0; i < (w ? 16 : 8); i++) begin
            logic [7:0] ix = b[i*8 +: 8];
            int k = w ? int'(ix[3:0]) : int'(ix[2:0]);
            r[i*8 +: 8] = ix[7] ? 8'h00 : a[k*8 +: 8];
        end
        return r;
    endfunction

    // Bench model of window extract from R6/R7/R8/R9.
    function automatic logic [127:0] m_extract(input logic [127:0] a,
                                               input logic [127:0] b,
                                               input logic [7:0] off,
                                               input logic w);
        logic [255:0] s;
        logic [127:0] r = '0;
        int n = w ? 16 : 8;
        s = w ? {a, b} : {128'h0, a[63:0], b[63:0]};
        for (int j = 0; j < n; j++) begin
            int p = int'(off) + j;
            if (p < 2*n) r[j*8 +: 8] = s[p*8 +: 8];
        end
        return r;
    endfunction

    // Apply one request, then sample away from the edge one cycle later.
    task automatic issue(input logic op, input logic w, input logic [127:0] a,
                         input logic [127:0] b, input logic [7:0] imm);
        @(negedge clk);
        req_valid = 1'b1; op_kind = op; full_width = w;
        opnd_a = a; opnd_b = b; shift_imm = imm;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    logic [127:0] ta;
    always_comb for (int i = 0; i < 16; i++) ta[i*8 +: 8] = 8'hA0 + 8'(i);

    task automatic t_reset;
        rst_n = 1'b0; req_valid = 1'b0; op_kind = 1'b0; full_width = 1'b1;
        opnd_a = '1; opnd_b = '1; shift_imm = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 128'(res_valid), 128'h0);
        check("R1 reset data", res_data, 128'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_lookup_basic;
        logic [127:0] idx;
        for (int i = 0; i < 16; i++) idx[i*8 +: 8] = 8'(i);
        issue(1'b0, 1'b1, ta, idx, 8'h00);
        check("R3 identity", res_data, ta);
        check("R2 valid after request", 128'(res_valid), 128'h1);
        for (int i = 0; i < 16; i++) idx[i*8 +: 8] = 8'(15 - i);
        issue(1'b0, 1'b1, ta, idx, 8'h00);
        check("R3 reversed", res_data, m_lookup(ta, idx, 1'b1));
        check("R3 reversed byte0", 128'(res_data[7:0]), 128'hAF);
        for (int n = 0; n < 4; n++) begin
            logic [127:0] ra = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] rb = {$urandom, $urandom, $urandom, $urandom};
            issue(1'b0, 1'b1, ra, rb, 8'h00);
            check("R3 R4 mixed pattern", res_data, m_lookup(ra, rb, 1'b1));
        end
    endtask

    task automatic t_lookup_clear;
        logic [127:0] idx = {16{8'h83}};
        issue(1'b0, 1'b1, ta, idx, 8'h00);
        check("R4 all cleared", res_data, 128'h0);
        idx = {{8{8'h81}}, {8{8'h02}}};
        issue(1'b0, 1'b1, ta, idx, 8'h00);
        check("R4 half cleared", res_data, {64'h0, {8{8'hA2}}});
    endtask

    task automatic t_lookup_junk_bits;
        issue(1'b0, 1'b1, ta, {16{8'h73}}, 8'h00);
        check("R5 wide junk bits", res_data, {16{8'hA3}});
        issue(1'b0, 1'b0, ta, {16{8'h7D}}, 8'h00);
        check("R5 narrow uses 3 bits", res_data, {64'h0, {8{8'hA5}}});
    endtask

    task automatic t_narrow_upper;
        logic [127:0] idx = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0706050403020100};
        issue(1'b0, 1'b0, {64'hDEAD_BEEF_0BAD_F00D, ta[63:0]}, idx, 8'h00);
        check("R9 narrow lookup", res_data, {64'h0, ta[63:0]});
        issue(1'b1, 1'b0, {64'h1234_5678_9ABC_DEF0, ta[63:0]},
              {64'h1111_2222_3333_4444, 64'h0}, 8'h04);
        check("R9 narrow extract ignores upper",
              res_data, {64'h0, 32'hA3A2A1A0, 32'h0});
    endtask

    task automatic t_extract_wide;
        logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
        issue(1'b1, 1'b1, ta, b, 8'd0);
        check("R6 offset 0 gives low operand", res_data, b);
        issue(1'b1, 1'b1, ta, b, 8'd16);
        check("R6 offset 16 gives high operand", res_data, ta);
        issue(1'b1, 1'b1, ta, b, 8'd5);
        check("R6 offset 5", res_data, m_extract(ta, b, 8'd5, 1'b1));
        issue(1'b1, 1'b1, ta, b, 8'd31);
        check("R6 R8 offset 31", res_data, {120'h0, 8'hAF});
    endtask

    task automatic t_extract_narrow;
        logic [127:0] b = {64'hFFFF_FFFF_FFFF_FFFF, 64'h1716151413121110};
        issue(1'b1, 1'b0, ta, b, 8'd3);
        check("R7 narrow offset 3", res_data, {64'h0, 64'hA2A1A0_1716151413});
        issue(1'b1, 1'b0, ta, b, 8'd8);
        check("R7 narrow offset 8", res_data, {64'h0, ta[63:0]});
    endtask

    task automatic t_extract_far;
        logic [127:0] b = {4{32'h5A5A_C3C3}};
        issue(1'b1, 1'b1, ta, b, 8'd20);
        check("R8 offset 20 partial", res_data, {32'h0, ta[127:32]});
        issue(1'b1, 1'b1, ta, b, 8'd32);
        check("R8 offset 32 zero", res_data, 128'h0);
        issue(1'b1, 1'b1, ta, b, 8'd200);
        check("R8 offset 200 zero", res_data, 128'h0);
        issue(1'b1, 1'b0, ta, b, 8'd16);
        check("R8 narrow offset 16 zero", res_data, 128'h0);
        issue(1'b1, 1'b0, ta, b, 8'd12);
        check("R8 narrow offset 12", res_data, {96'h0, ta[63:32]});
    endtask

    task automatic t_idle_hold;
        logic [127:0] held;
        issue(1'b0, 1'b1, ta, {16{8'h01}}, 8'h00);
        held = res_data;
        check("R2 valid high", 128'(res_valid), 128'h1);
        opnd_a = '0; opnd_b = {16{8'h0F}}; op_kind = 1'b1; shift_imm = 8'd7;
        @(negedge clk);
        check("R2 valid drops", 128'(res_valid), 128'h0);
        check("R10 data held", res_data, held);
        @(negedge clk);
        check("R10 data still held", res_data, {16{8'hA1}});
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_lookup_basic();
        t_lookup_clear();
        t_lookup_junk_bits();
        t_narrow_upper();
        t_extract_wide();
        t_extract_narrow();
        t_extract_far();
        t_idle_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule